// File: doc/BRIEF.md
# Keyed Programmable Clock Divider

This block divides its input clock by an integer ratio from 1 to 32 and produces two outputs: a registered divided clock and a single-cycle enable pulse that marks the start of each output period. The ratio is set through a 32-bit write port. Only the low 12 bits of a written word are used. A word is accepted as a ratio request only when its upper seven bits of that field match a fixed key. In that case the lowest five bits give the divisor code. Any other word is treated as a request for the safe fallback ratio of 31.

A ratio change never shortens or stretches the output period that is running when the write occurs. The new code is held as pending and is adopted only when the current period finishes. The read port always shows the key together with the divisor code that is currently active. Software can therefore confirm when a change has taken hold. The reset input is asynchronous and active-low. Its release is synchronised inside the block, which adds two clock cycles before the divider starts counting.

Top module: `keyed_clkdiv`

## Requirements
- R1: During reset and until counting starts, the active divisor code is 16, `rd_data_o` reads 0x0000_0AB0, and `clk_o` and `tick_o` are low. After release the divider runs at divide-by-16.
- R2: On a write, bits 31:12 of `wr_data_i` are ignored. Only bits 11:0 form the control word.
- R3: A control word in the keyed range 0xAA0..0xABF is accepted. Its bits 4:0 become the divisor code, and codes 1..31 divide by that number.
- R4: A divisor code of 0 divides by 32.
- R5: A control word outside 0xAA0..0xABF sets the divisor code to 31. This includes the neighbours 0xA9F and 0xAC0.
- R6: A write never changes the length of the output period in progress. The period containing the write keeps the old ratio, and the following period uses the new one.
- R7: `rd_data_o` equals 0x0000_0AA0 plus the active 5-bit divisor code, where code 0 stands for divide-by-32.
- R8: For a ratio N of 2 or more, each period starts with `clk_o` high for floor(N/2) input cycles, followed by ceil(N/2) low cycles.
- R9: `tick_o` is high for exactly one input cycle per output period: the first cycle of the period.
- R10: At divide-by-1, `tick_o` is high on every cycle and `clk_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised internally |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | 32 | Write word; only bits 11:0 are decoded |
| rd_data_o | output | 32 | Key plus the currently active divisor code |
| clk_o | output | 1 | Registered divided clock |
| tick_o | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The divider is driven with the reset ratio, then with codes 1, 7, 0, 31 and 8. These cover pass-through, odd duty cycle, the wrap of code 0 to 32, and an even ratio; for each one the bench measures both the period and the high time. Out-of-range words are tried at both neighbours of the keyed window and at an arbitrary value, which tells the fallback apart from a simple truncation of the low bits. A word with garbage in bits 31:12 shows that those bits are ignored. A write issued in the middle of a period checks that the period in progress keeps the old length and the next one takes the new length.

// File: rtl/keyed_clkdiv_pkg.sv
package keyed_clkdiv_pkg;

  localparam int unsigned DFLT_BUS_W  = 32;
  localparam int unsigned DFLT_CTRL_W = 12;
  localparam int unsigned DFLT_CODE_W = 5;

  // Ratio selected by a divisor code: the all-zero code means the maximum
  // ratio, one past the largest code value.
  function automatic logic [DFLT_CODE_W:0] code_to_ratio(input logic [DFLT_CODE_W-1:0] code);
    code_to_ratio = {(code == '0), code};
  endfunction

endpackage

// File: rtl/keyed_clkdiv_rstsync.sv
module keyed_clkdiv_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_no = stage2_q;

endmodule

// File: rtl/keyed_clkdiv_decode.sv
module keyed_clkdiv_decode #(
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned CTRL_W   = 12,
  parameter int unsigned CODE_W   = 5,
  parameter logic [CTRL_W-1:0] KEY = 12'hAA0,
  parameter logic [CODE_W-1:0] FALLBACK_CODE = 5'd31
) (
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int unsigned KEY_W = CTRL_W - CODE_W;

  logic [CTRL_W-1:0] ctrl_word;
  logic              key_match;

  always_comb begin
    ctrl_word = wr_data_i[CTRL_W-1:0];
    key_match = (ctrl_word[CTRL_W-1:CODE_W] == KEY[CTRL_W-1:CODE_W]);
    code_o    = key_match ? ctrl_word[CODE_W-1:0] : FALLBACK_CODE;
  end

  logic [KEY_W-1:0] unused_key_low;
  assign unused_key_low = KEY[CTRL_W-1:CODE_W];

endmodule

// File: rtl/keyed_clkdiv_ratio.sv
module keyed_clkdiv_ratio #(
  parameter int unsigned CODE_W = 5,
  parameter logic [CODE_W-1:0] RESET_CODE = 5'd16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              period_end_i,
  output logic [CODE_W-1:0] act_code_o,
  output logic [CODE_W-1:0] act_code_nxt_o
);

  logic [CODE_W-1:0] pend_q, pend_d;
  logic [CODE_W-1:0] act_q,  act_d;
  logic              pend_en;
  logic              act_en;

  always_comb begin
    pend_en = wr_en_i;
    pend_d  = wr_code_i;
    act_en  = period_end_i;
    act_d   = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RESET_CODE;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RESET_CODE;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign act_code_o     = act_q;
  assign act_code_nxt_o = act_en ? act_d : act_q;

endmodule

// File: rtl/keyed_clkdiv_counter.sv
module keyed_clkdiv_counter #(
  parameter int unsigned CODE_W = 5,
  parameter logic [CODE_W-1:0] RESET_CODE = 5'd16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] act_code_i,
  input  logic [CODE_W-1:0] act_code_nxt_i,
  output logic              period_end_o,
  output logic              clk_o,
  output logic              tick_o
);

  localparam int unsigned RATIO_W = CODE_W + 1;
  localparam logic [RATIO_W-1:0] RESET_RATIO = {(RESET_CODE == '0), RESET_CODE};
  localparam logic [CODE_W-1:0]  CNT_RESET   = CODE_W'(RESET_RATIO - 1'b1);

  logic [CODE_W-1:0]  cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_cur, ratio_nxt;
  logic               clk_q, clk_d;
  logic               tick_q, tick_d;

  always_comb begin
    ratio_cur    = {(act_code_i == '0), act_code_i};
    ratio_nxt    = {(act_code_nxt_i == '0), act_code_nxt_i};
    period_end_o = ({1'b0, cnt_q} == (ratio_cur - 1'b1));
    cnt_d        = period_end_o ? '0 : cnt_q + 1'b1;
    tick_d       = (cnt_d == '0);
    if (ratio_nxt == RATIO_W'(1)) begin
      clk_d = 1'b1;
    end else begin
      clk_d = ({1'b0, cnt_d} < (ratio_nxt >> 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_RESET;
      clk_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      clk_q  <= clk_d;
      tick_q <= tick_d;
    end
  end

  assign clk_o  = clk_q;
  assign tick_o = tick_q;

endmodule

// File: rtl/keyed_clkdiv.sv
module keyed_clkdiv #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned CTRL_W = 12,
  parameter int unsigned CODE_W = 5,
  parameter logic [CTRL_W-1:0] KEY           = 12'hAA0,
  parameter logic [CODE_W-1:0] RESET_CODE    = 5'd16,
  parameter logic [CODE_W-1:0] FALLBACK_CODE = 5'd31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             clk_o,
  output logic             tick_o
);

  localparam int unsigned PAD_W = BUS_W - CTRL_W;

  logic              rst_n_sync;
  logic [CODE_W-1:0] wr_code;
  logic [CODE_W-1:0] act_code;
  logic [CODE_W-1:0] act_code_nxt;
  logic              wrap;

  keyed_clkdiv_rstsync u_rstsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  keyed_clkdiv_decode #(
    .BUS_W         (BUS_W),
    .CTRL_W        (CTRL_W),
    .CODE_W        (CODE_W),
    .KEY           (KEY),
    .FALLBACK_CODE (FALLBACK_CODE)
  ) u_decode (
    .wr_data_i (wr_data_i),
    .code_o    (wr_code)
  );

  keyed_clkdiv_ratio #(
    .CODE_W     (CODE_W),
    .RESET_CODE (RESET_CODE)
  ) u_ratio (
    .clk_i          (clk_i),
    .rst_ni         (rst_n_sync),
    .wr_en_i        (wr_en_i),
    .wr_code_i      (wr_code),
    .period_end_i   (wrap),
    .act_code_o     (act_code),
    .act_code_nxt_o (act_code_nxt)
  );

  keyed_clkdiv_counter #(
    .CODE_W     (CODE_W),
    .RESET_CODE (RESET_CODE)
  ) u_counter (
    .clk_i          (clk_i),
    .rst_ni         (rst_n_sync),
    .act_code_i     (act_code),
    .act_code_nxt_i (act_code_nxt),
    .period_end_o   (wrap),
    .clk_o          (clk_o),
    .tick_o         (tick_o)
  );

  assign rd_data_o = {{PAD_W{1'b0}}, KEY[CTRL_W-1:CODE_W], act_code};

endmodule

// File: rtl/keyed_clkdiv_chk.sv
module keyed_clkdiv_chk #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned CTRL_W = 12,
  parameter int unsigned CODE_W = 5,
  parameter logic [CTRL_W-1:0] KEY = 12'hAA0
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [BUS_W-1:0] rd_data_o,
  input logic             clk_o,
  input logic             tick_o,
  input logic             wrap
);

  AST_READ_KEY_FIELD: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_data_o[BUS_W-1:CODE_W] == {{(BUS_W-CTRL_W){1'b0}}, KEY[CTRL_W-1:CODE_W]}); // R7

  AST_RATIO_SWAP_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(rd_data_o) |-> tick_o); // R6

  AST_PERIOD_STARTS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_o |-> clk_o); // R8

  AST_WRAP_GIVES_TICK: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap |=> tick_o); // R9

  AST_TICK_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_o && rd_data_o[CODE_W-1:0] != CODE_W'(1) && !wrap) |=> !tick_o); // R9

  AST_DIV1_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_data_o[CODE_W-1:0] == CODE_W'(1) && tick_o) |-> clk_o); // R10

endmodule

bind keyed_clkdiv keyed_clkdiv_chk #(
  .BUS_W  (BUS_W),
  .CTRL_W (CTRL_W),
  .CODE_W (CODE_W),
  .KEY    (KEY)
) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_sync),
  .rd_data_o (rd_data_o),
  .clk_o     (clk_o),
  .tick_o    (tick_o),
  .wrap      (wrap)
);

// File: tb/keyed_clkdiv_tb.sv
module keyed_clkdiv_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        clk_out;
  logic        tick;

  int n_checks = 0;
  int n_errors = 0;

  keyed_clkdiv u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .clk_o     (clk_out),
    .tick_o    (tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
  endtask

  // Called at a negedge where tick is high; returns period and high count.
  task automatic measure(output int period, output int high);
    period = 0;
    high   = 0;
    do begin
      period++;
      if (clk_out) high++;
      @(negedge clk);
    end while (!tick);
  endtask

  task automatic program_and_check(input string req, input logic [31:0] w,
                                   input int exp_code);
    int p, h, n;
    n = (exp_code == 0) ? 32 : exp_code;
    write_word(w);
    wait_tick();
    wait_tick();
    check({req, " readback"}, int'(rd_data), 32'hAA0 + exp_code);
    measure(p, h);
    check({req, " period"}, p, n);
    check({req, " high time (R8)"}, h, (n == 1) ? 1 : n / 2);
  endtask

  task automatic test_reset();
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset readback", int'(rd_data), 32'h0AB0);
    check("R1 reset clk_o", int'(clk_out), 0);
    check("R1 reset tick_o", int'(tick), 0);
    rst_n = 1'b1;
  endtask

  task automatic test_default_ratio();
    int p, h;
    wait_tick();
    measure(p, h);
    check("R1 default period", p, 16);
    check("R1 default high time", h, 8);
  endtask

  task automatic test_div1();
    int p, h;
    program_and_check("R10 R3 code 1", 32'h0000_0AA1, 1);
    for (int i = 0; i < 4; i++) begin
      measure(p, h);
      check("R10 divide-by-1 period", p, 1);
      check("R10 divide-by-1 clk_o high", h, 1);
    end
  endtask

  task automatic test_mid_period_write();
    int n;
    program_and_check("R3 code 8", 32'h0000_0AA8, 8);
    // now at the first cycle of a divide-by-8 period
    n = 0;
    do begin
      if (n == 2) begin
        wr_en   = 1'b1;
        wr_data = 32'h0000_0AA5;
      end else begin
        wr_en = 1'b0;
      end
      n++;
      @(negedge clk);
    end while (!tick);
    wr_en = 1'b0;
    check("R6 period holding the write keeps old ratio", n, 8);
    begin
      int p, h;
      measure(p, h);
      check("R6 next period uses new ratio", p, 5);
      check("R6 readback after swap", int'(rd_data), 32'hAA5);
    end
  endtask

  initial begin
    test_reset();
    test_default_ratio();
    program_and_check("R3 odd code 7", 32'h0000_0AA7, 7);
    program_and_check("R4 code 0 is 32", 32'h0000_0AA0, 0);
    program_and_check("R3 top code 31", 32'h0000_0ABF, 31);
    program_and_check("R2 upper bits ignored", 32'hFFFF_FAA4, 4);
    program_and_check("R5 below window", 32'h0000_0A9F, 31);
    program_and_check("R2 R3 restore 2", 32'h0000_0AA2, 2);
    program_and_check("R5 above window", 32'h0000_0AC0, 31);
    program_and_check("R2 R3 restore 6", 32'h0000_0AA6, 6);
    program_and_check("R5 R7 arbitrary word", 32'h0000_0123, 31);
    test_div1();
    test_mid_period_write();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule